// File: doc/BRIEF.md
# Frame-Sync Power Sequencer

This block decides when the digital side of a voice codec is powered and when its serial PCM data output may leave high impedance. Its inputs are a free-running reference clock, a power-down pin, and the transmit and receive frame-sync lines. Its outputs are a power-up flag and an output-enable gate for the PCM data driver.

A rising edge on either frame-sync line wakes the block, unless the power-down pin is holding it down. The power-down pin forces power-down only when it sits high for a run of `PIN_HOLD` reference cycles. A pin that is held low allows power-up. So does a pin that toggles as a clock, because its high phases are always shorter than that run. If no new frame-sync edge arrives for `TIMEOUT_CYCLES` reference cycles, the block powers down. The default of 2048 cycles of a 2.048 MHz clock gives about 1 ms. After each power-up the data output stays in high impedance until the second transmit frame-sync edge. Both frame-sync lines and the pin pass through two-flop synchronisers first. Frame-sync rising edges are detected after synchronisation.

Top module: `fs_power_seq`

## Requirements
- R1: After reset, `pwr_up` and `pcm_oe` are both 0.
- R2: While `pwrdn_pin` is held high, `pwr_up` and `pcm_oe` are 0 within `PIN_HOLD`+3 reference cycles. They then stay 0 for as long as the pin stays high.
- R3: If `pwrdn_pin` is held low, power-up is allowed. It is also allowed if the pin toggles with high phases shorter than `PIN_HOLD` cycles.
- R4: While power-up is allowed, a rising edge on `fs_tx` or `fs_rx` sets `pwr_up`. `pwr_up` is 0 up to two reference edges after the input rises and is 1 after the third edge.
- R5: With no new frame-sync rising edge, `pwr_up` falls `TIMEOUT_CYCLES` reference edges after the edge that took in the last frame-sync rise.
- R6: `pcm_oe` goes to 1 on the second `fs_tx` rising edge counted since power-up. A transmit edge that causes the wake-up counts as the first. Receive edges never count.
- R7: Frame-sync edges that arrive while the pin forces power-down are ignored. After release, the block stays down until a fresh edge arrives, and the transmit count starts from zero.
- R8: Each new power-up restarts the transmit edge count from zero, including a power-up that follows a timeout.
- R9: `pcm_oe` is never 1 while `pwr_up` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_pin | input | 1 | Power-down pin; a long high level forces power-down |
| fs_tx | input | 1 | Transmit frame-sync line |
| fs_rx | input | 1 | Receive frame-sync line |
| pwr_up | output | 1 | 1 while the codec's digital side is powered |
| pcm_oe | output | 1 | 1 when the PCM data output may drive; 0 means high impedance |

## Verification
The bench feeds the power-down pin as a fast clock. A design that treats any high sample as a power-down request would never wake. The bench sends frame-sync edges while the pin forces power-down and then releases the pin. This catches a design that latches those edges and wakes on its own, or that enables the output after a single later edge. The timeout is sampled one cycle before and one cycle after its nominal point, which exposes an off-by-many counter. Wake-ups through the receive line and after a timeout confirm the transmit count restarts. A design that carries the count over would enable the output one pulse early.

// File: rtl/fs_power_seq.sv
module fs_power_seq #(
  parameter int TIMEOUT_CYCLES = 2048,
  parameter int PIN_HOLD       = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwrdn_pin,
  input  logic fs_tx,
  input  logic fs_rx,
  output logic pwr_up,
  output logic pcm_oe
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam int HW = $clog2(PIN_HOLD + 1);

  logic [2:0]    tx_q, rx_q;
  logic [1:0]    pin_q;
  logic [HW-1:0] hi_cnt;
  logic [TW-1:0] idle_cnt;
  logic [1:0]    tx_cnt;
  logic          pwr_q;

  logic tx_rise, rx_rise, any_rise, forced, expire, wake;

  assign tx_rise  = tx_q[1] & ~tx_q[2];
  assign rx_rise  = rx_q[1] & ~rx_q[2];
  assign any_rise = tx_rise | rx_rise;
  assign forced   = (hi_cnt == HW'(PIN_HOLD));
  assign expire   = pwr_q & ~any_rise & (idle_cnt == TW'(TIMEOUT_CYCLES - 1));
  assign wake     = ~pwr_q & ~forced & any_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q     <= '0;
      rx_q     <= '0;
      pin_q    <= '0;
      hi_cnt   <= '0;
      idle_cnt <= '0;
      tx_cnt   <= '0;
      pwr_q    <= 1'b0;
    end else begin
      tx_q  <= {tx_q[1:0], fs_tx};
      rx_q  <= {rx_q[1:0], fs_rx};
      pin_q <= {pin_q[0], pwrdn_pin};

      if (!pin_q[1])
        hi_cnt <= '0;
      else if (!forced)
        hi_cnt <= hi_cnt + 1'b1;

      if (forced || expire)
        pwr_q <= 1'b0;
      else if (wake)
        pwr_q <= 1'b1;

      if (!pwr_q || any_rise)
        idle_cnt <= '0;
      else
        idle_cnt <= idle_cnt + 1'b1;

      if (forced || expire || (!pwr_q && !wake))
        tx_cnt <= '0;
      else if (wake)
        tx_cnt <= {1'b0, tx_rise};
      else if (tx_rise && tx_cnt != 2'd2)
        tx_cnt <= tx_cnt + 1'b1;
    end
  end

  assign pwr_up = pwr_q;
  assign pcm_oe = pwr_q & (tx_cnt == 2'd2);
endmodule

module fs_power_seq_chk #(
  parameter int TIMEOUT_CYCLES = 2048,
  parameter int TW             = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_up,
  input logic          pcm_oe,
  input logic          tx_rise,
  input logic          rx_rise,
  input logic          forced,
  input logic [TW-1:0] idle_cnt
);
  // R9
  oe_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_oe |-> pwr_up);

  // R4
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_up) |-> $past(tx_rise | rx_rise));

  // R2
  forced_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    forced |=> !pwr_up);

  // R5
  timeout_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwr_up) && !$past(forced)) |-> ($past(idle_cnt) == TW'(TIMEOUT_CYCLES - 1)));

  // R6
  oe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcm_oe) |-> $past(tx_rise));
endmodule

bind fs_power_seq fs_power_seq_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .pcm_oe(pcm_oe),
  .tx_rise(tx_rise), .rx_rise(rx_rise), .forced(forced), .idle_cnt(idle_cnt)
);

// File: tb/test_fs_power_seq.sv
module test_fs_power_seq;
  localparam int TO   = 2048;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrdn_pin = 1'b0;
  logic fs_tx = 1'b0;
  logic fs_rx = 1'b0;
  logic pin_clk_en = 1'b0;
  logic pwr_up, pcm_oe;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fs_power_seq #(.TIMEOUT_CYCLES(TO), .PIN_HOLD(HOLD)) i_fs_power_seq (
    .clk(clk), .rst_n(rst_n), .pwrdn_pin(pwrdn_pin),
    .fs_tx(fs_tx), .fs_rx(fs_rx), .pwr_up(pwr_up), .pcm_oe(pcm_oe)
  );

  always @(negedge clk) if (pin_clk_en) pwrdn_pin <= ~pwrdn_pin;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input bit tx, input bit rx);
    @(negedge clk);
    fs_tx = tx; fs_rx = rx;
    waitn(2);
    fs_tx = 1'b0; fs_rx = 1'b0;
    waitn(3);
  endtask

  task automatic t_reset();
    chk("R1 pwr_up", pwr_up, 1'b0);
    chk("R1 pcm_oe", pcm_oe, 1'b0);
  endtask

  task automatic t_wake_latency();
    @(negedge clk);
    fs_rx = 1'b1;
    waitn(2);
    chk("R4 before third edge", pwr_up, 1'b0);
    waitn(1);
    chk("R4 after third edge", pwr_up, 1'b1);
    fs_rx = 1'b0;
    waitn(3);
    chk("R6 rx does not enable", pcm_oe, 1'b0);
    pulse(1, 0);
    chk("R6 one tx edge", pcm_oe, 1'b0);
    pulse(1, 0);
    chk("R6 second tx edge", pcm_oe, 1'b1);
  endtask

  task automatic t_timeout();
    waitn(TO - 4);
    chk("R5 still up before timeout", pwr_up, 1'b1);
    waitn(3);
    chk("R5 down after timeout", pwr_up, 1'b0);
    chk("R9 oe off when down", pcm_oe, 1'b0);
  endtask

  task automatic t_restart();
    pulse(1, 0);
    chk("R8 tx wake powers up", pwr_up, 1'b1);
    chk("R8 wake edge counts once", pcm_oe, 1'b0);
    pulse(1, 0);
    chk("R8 second tx after wake", pcm_oe, 1'b1);
    waitn(TO + 10);
    chk("R5 timed out again", pwr_up, 1'b0);
  endtask

  task automatic t_force();
    pulse(1, 0);
    pulse(1, 0);
    chk("R6 enabled before force", pcm_oe, 1'b1);
    pwrdn_pin = 1'b1;
    waitn(HOLD + 4);
    chk("R2 forced down", pwr_up, 1'b0);
    chk("R2 oe off", pcm_oe, 1'b0);
    pulse(1, 0);
    pulse(0, 1);
    pulse(1, 0);
    chk("R7 pulses ignored while forced", pwr_up, 1'b0);
    chk("R2 still down", pcm_oe, 1'b0);
    pwrdn_pin = 1'b0;
    waitn(5);
    chk("R7 no wake on release", pwr_up, 1'b0);
    pulse(0, 1);
    chk("R7 fresh rx wakes", pwr_up, 1'b1);
    pulse(1, 0);
    chk("R7 count restarted", pcm_oe, 1'b0);
    pulse(1, 0);
    chk("R7 second fresh tx", pcm_oe, 1'b1);
  endtask

  task automatic t_pin_clock();
    pwrdn_pin = 1'b1;
    waitn(HOLD + 4);
    chk("R2 down before clock", pwr_up, 1'b0);
    pin_clk_en = 1'b1;
    waitn(10);
    pulse(0, 1);
    chk("R3 wake with clocked pin", pwr_up, 1'b1);
    waitn(50);
    chk("R3 stays up with clocked pin", pwr_up, 1'b1);
    pin_clk_en = 1'b0;
    @(negedge clk);
    pwrdn_pin = 1'b0;
  endtask

  initial begin
    waitn(3);
    rst_n = 1'b1;
    waitn(2);
    t_reset();
    t_wake_latency();
    t_timeout();
    t_restart();
    t_force();
    t_pin_clock();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule